// File: doc/BRIEF.md
# In-Order Dual-Issue Controller

This block sits between an instruction fetch buffer and three execution units (integer, floating point, memory). It holds one pair of decoded instructions, checks every cycle whether each slot's target unit is free and whether its registers are clear of in-flight writes, and issues zero, one or two instructions. Issue never runs out of program order. The first slot must be able to go before the second may go. Both go together only when the pair is aligned, the units differ and the second does not depend on the first.

A partial issue keeps the pair and clears only the slot that went. The remaining instruction later issues alone, and no new instruction moves up beside it. The fetch buffer is asked for a new pair only when every valid slot of the current pair has issued. An internal scoreboard marks destination registers of issued instructions as pending until a writeback port clears them. A synchronous flush empties the pair and the scoreboard.

Top module: `idc_dual_issue`

## Requirements
- R1: When the held pair is aligned, both slots are free, their units differ and there is no register dependency between them, `issue0` and `issue1` are both high in the same cycle.
- R2: If slot 0 is blocked, `issue1` stays low even when slot 1 could go on its own.
- R3: Two instructions that target the same unit never issue together. Slot 0 issues alone.
- R4: An unaligned pair (`fb_aligned`=0 at load) issues slot 0 alone and slot 1 alone on a later cycle, never both in one cycle.
- R5: After a partial issue, `fb_advance` stays low, slot 1 keeps its contents, and fetch inputs are ignored until slot 1 has issued.
- R6: `fb_advance` is high exactly when every valid slot issues this cycle, or when the pair is empty. A pair offered with `fb_valid` is loaded at that clock edge.
- R7: An issued instruction with `wr`=1 marks its destination pending from the next cycle. An instruction whose source or (when writing) destination is pending does not issue. A `wb_valid` pulse for that register clears the mark at the next edge.
- R8: If slot 0 writes the register that slot 1 reads, or both write the same register, slot 0 issues alone.
- R9: While `flush` is high nothing issues and `fb_advance` is low. At that edge both slot valid flags and all pending marks clear.
- R10: After reset the pair is empty, no register is pending, `fb_advance` is high and both issue strobes are low.
- R11: Unit codes are 0 integer, 1 floating point and 2 memory. Bit n of `unit_busy` is the busy flag of unit code n. `issue_unit0` and `issue_unit1` show the held slot's unit code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Synchronous clear of the pair and the scoreboard |
| fb_valid | input | 1 | Fetch buffer offers a new pair |
| fb_aligned | input | 1 | Offered pair starts at an even position |
| fb_unit0 | input | 2 | Slot 0 unit code |
| fb_src0 | input | 3 | Slot 0 source register |
| fb_dst0 | input | 3 | Slot 0 destination register |
| fb_wr0 | input | 1 | Slot 0 writes its destination |
| fb_unit1 | input | 2 | Slot 1 unit code |
| fb_src1 | input | 3 | Slot 1 source register |
| fb_dst1 | input | 3 | Slot 1 destination register |
| fb_wr1 | input | 1 | Slot 1 writes its destination |
| unit_busy | input | 3 | Per-unit busy flags, indexed by unit code |
| wb_valid | input | 1 | A register write completes |
| wb_reg | input | 3 | Register whose pending mark clears |
| issue0 | output | 1 | Slot 0 issues this cycle |
| issue1 | output | 1 | Slot 1 issues this cycle |
| issue_unit0 | output | 2 | Unit code of slot 0 |
| issue_unit1 | output | 2 | Unit code of slot 1 |
| fb_advance | output | 1 | Request for a new pair |

## Verification
The assertions assume that unit codes are only 0 to 2, that `wb_valid` names only registers that are pending, and that no pair is offered on the cycle `flush` is high. The stimulus uses only the three legal codes. It raises writeback only for a register the bench marked pending, and it holds `fb_valid` low whenever it raises `flush`. The unit, alignment and busy sweep runs from a flushed state with no register writes, so the scoreboard cannot hide a resource decision.

// File: rtl/idc_pkg.sv
// Shared widths and the decoded-instruction record for the dual-issue controller.
// Assumes 2**IDC_UNIT_W >= IDC_NUM_UNITS.
package idc_pkg;
    parameter int IDC_REG_W     = 3;
    parameter int IDC_UNIT_W    = 2;
    parameter int IDC_NUM_UNITS = 3;
    parameter int IDC_NREGS     = 1 << IDC_REG_W;

    typedef struct packed {
        logic [IDC_UNIT_W-1:0] unit;
        logic [IDC_REG_W-1:0]  src;
        logic [IDC_REG_W-1:0]  dst;
        logic                  wr;
    } idc_instr_t;
endpackage

// File: rtl/idc_scoreboard.sv
// Pending-write scoreboard: one bit per register, set by issue, cleared by writeback.
// Assumes a set and a clear of the same register in one cycle means a new write (set wins).
module idc_scoreboard #(
    parameter int REG_W = idc_pkg::IDC_REG_W,
    localparam int NREGS = 1 << REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             set0_en,
    input  logic [REG_W-1:0] set0_idx,
    input  logic             set1_en,
    input  logic [REG_W-1:0] set1_idx,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_idx,
    output logic [NREGS-1:0] pending
);
    logic [NREGS-1:0] pend_d;

    // Per-register next value: keep unless cleared, then apply the issue sets.
    for (genvar g = 0; g < NREGS; g++) begin : g_bit
        always_comb begin
            pend_d[g] = (pending[g] && !(clr_en && clr_idx == REG_W'(g)))
                      || (set0_en && set0_idx == REG_W'(g))
                      || (set1_en && set1_idx == REG_W'(g));
        end
    end

    // State update with reset and flush clearing every mark.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) pending <= '0;
        else                 pending <= pend_d;
    end

    assert_mark_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set0_en && !flush) |=> pending[$past(set0_idx)]);

    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (pending == '0));
endmodule

// File: rtl/idc_slot_check.sv
// Readiness of one slot: valid, legal and free unit, no pending source or destination.
// Assumes unit codes at or above NUM_UNITS are treated as permanently busy.
module idc_slot_check
    import idc_pkg::*;
#(
    parameter int NUM_UNITS = IDC_NUM_UNITS,
    localparam int CODES = 1 << IDC_UNIT_W,
    localparam int PAD = CODES - NUM_UNITS
) (
    input  logic                 vld,
    input  idc_instr_t           ins,
    input  logic [NUM_UNITS-1:0] busy,
    input  logic [IDC_NREGS-1:0] pend,
    output logic                 ready
);
    logic [CODES-1:0] busy_ext;

    // Widen the busy vector so every code indexes a defined bit.
    always_comb begin
        busy_ext = {{PAD{1'b1}}, busy};
    end

    // Slot may go when its unit is free and no hazard on its registers.
    always_comb begin
        ready = vld && !busy_ext[ins.unit] && !pend[ins.src]
             && !(ins.wr && pend[ins.dst]);
    end
endmodule

// File: rtl/idc_pair_reg.sv
// Holds the current instruction pair; loads a new pair on request, retires slots as they issue.
// Assumes load is only requested when every valid slot issues this cycle.
module idc_pair_reg
    import idc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       load,
    input  logic       new_aligned,
    input  idc_instr_t new0,
    input  idc_instr_t new1,
    input  logic       took0,
    input  logic       took1,
    output logic       v0,
    output logic       v1,
    output logic       aligned_q,
    output idc_instr_t s0,
    output idc_instr_t s1
);
    // Valid flags: cleared by reset or flush, set by a load, dropped on issue.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            v0 <= 1'b0;
            v1 <= 1'b0;
        end else if (load) begin
            v0 <= 1'b1;
            v1 <= 1'b1;
        end else begin
            v0 <= v0 && !took0;
            v1 <= v1 && !took1;
        end
    end

    // Payload: captured only when a new pair is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s0        <= '0;
            s1        <= '0;
            aligned_q <= 1'b0;
        end else if (load && !flush) begin
            s0        <= new0;
            s1        <= new1;
            aligned_q <= new_aligned;
        end
    end
endmodule

// File: rtl/idc_dual_issue.sv
// In-order dual-issue controller. Decides per cycle whether zero, one or two held
// instructions issue, and when to request the next pair from the fetch buffer.
// Assumes unit codes below IDC_NUM_UNITS and writebacks only for pending registers.
module idc_dual_issue
    import idc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     fb_valid,
    input  logic                     fb_aligned,
    input  logic [IDC_UNIT_W-1:0]    fb_unit0,
    input  logic [IDC_REG_W-1:0]     fb_src0,
    input  logic [IDC_REG_W-1:0]     fb_dst0,
    input  logic                     fb_wr0,
    input  logic [IDC_UNIT_W-1:0]    fb_unit1,
    input  logic [IDC_REG_W-1:0]     fb_src1,
    input  logic [IDC_REG_W-1:0]     fb_dst1,
    input  logic                     fb_wr1,
    input  logic [IDC_NUM_UNITS-1:0] unit_busy,
    input  logic                     wb_valid,
    input  logic [IDC_REG_W-1:0]     wb_reg,
    output logic                     issue0,
    output logic                     issue1,
    output logic [IDC_UNIT_W-1:0]    issue_unit0,
    output logic [IDC_UNIT_W-1:0]    issue_unit1,
    output logic                     fb_advance
);
    localparam int SLOTS = 2;

    idc_instr_t             new_ins [SLOTS];
    idc_instr_t             held    [SLOTS];
    logic       [SLOTS-1:0] held_v;
    logic       [SLOTS-1:0] rdy;
    logic                   aligned_q;
    logic [IDC_NREGS-1:0]   pending;
    logic                   intra_dep;
    logic                   pair_ok;
    logic                   load;

    // Pack the fetch-buffer fields into instruction records.
    always_comb begin
        new_ins[0] = '{unit: fb_unit0, src: fb_src0, dst: fb_dst0, wr: fb_wr0};
        new_ins[1] = '{unit: fb_unit1, src: fb_src1, dst: fb_dst1, wr: fb_wr1};
    end

    idc_pair_reg u_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .load       (load),
        .new_aligned(fb_aligned),
        .new0       (new_ins[0]),
        .new1       (new_ins[1]),
        .took0      (issue0),
        .took1      (issue1),
        .v0         (held_v[0]),
        .v1         (held_v[1]),
        .aligned_q  (aligned_q),
        .s0         (held[0]),
        .s1         (held[1])
    );

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        idc_slot_check #(.NUM_UNITS(IDC_NUM_UNITS)) u_chk (
            .vld  (held_v[g]),
            .ins  (held[g]),
            .busy (unit_busy),
            .pend (pending),
            .ready(rdy[g])
        );
    end

    idc_scoreboard #(.REG_W(IDC_REG_W)) u_sb (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .set0_en (issue0 && held[0].wr),
        .set0_idx(held[0].dst),
        .set1_en (issue1 && held[1].wr),
        .set1_idx(held[1].dst),
        .clr_en  (wb_valid),
        .clr_idx (wb_reg),
        .pending (pending)
    );

    // Dependencies inside the pair that forbid issuing both together.
    always_comb begin
        intra_dep = held[0].wr && ((held[0].dst == held[1].src)
                 || (held[1].wr && held[0].dst == held[1].dst));
        pair_ok   = aligned_q && rdy[0] && !intra_dep
                 && (held[0].unit != held[1].unit);
    end

    // Issue strobes: slot 1 goes alone only once slot 0 has left.
    always_comb begin
        issue0 = !flush && rdy[0];
        issue1 = !flush && rdy[1] && (!held_v[0] || pair_ok);
    end

    // Request a new pair when the held one empties this cycle.
    always_comb begin
        fb_advance  = !flush && (!held_v[0] || issue0) && (!held_v[1] || issue1);
        load        = fb_advance && fb_valid;
        issue_unit0 = held[0].unit;
        issue_unit1 = held[1].unit;
    end

    assert_in_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue1 && held_v[0]) |-> issue0);

    assert_distinct_units_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue0 && issue1) |-> (issue_unit0 != issue_unit1));

    assert_dual_needs_alignment_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue0 && issue1) |-> aligned_q);

    assert_partial_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue0 && held_v[1] && !issue1) |=> (held_v[1] && !held_v[0]));

    assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!issue0 && !issue1 && !fb_advance));

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (held_v == '0));
endmodule

// File: tb/idc_dual_issue_tb.sv
`timescale 1ns/1ps
module idc_dual_issue_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush = 1'b0;
    logic       fb_valid = 1'b0;
    logic       fb_aligned = 1'b0;
    logic [1:0] fb_unit0 = '0, fb_unit1 = '0;
    logic [2:0] fb_src0 = '0, fb_dst0 = '0, fb_src1 = '0, fb_dst1 = '0;
    logic       fb_wr0 = 1'b0, fb_wr1 = 1'b0;
    logic [2:0] unit_busy = '0;
    logic       wb_valid = 1'b0;
    logic [2:0] wb_reg = '0;
    logic       issue0, issue1, fb_advance;
    logic [1:0] issue_unit0, issue_unit1;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    idc_dual_issue dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .fb_valid(fb_valid),
        .fb_aligned(fb_aligned), .fb_unit0(fb_unit0), .fb_src0(fb_src0),
        .fb_dst0(fb_dst0), .fb_wr0(fb_wr0), .fb_unit1(fb_unit1),
        .fb_src1(fb_src1), .fb_dst1(fb_dst1), .fb_wr1(fb_wr1),
        .unit_busy(unit_busy), .wb_valid(wb_valid), .wb_reg(wb_reg),
        .issue0(issue0), .issue1(issue1), .issue_unit0(issue_unit0),
        .issue_unit1(issue_unit1), .fb_advance(fb_advance)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic offer(input int u0, input int u1, input bit al,
                         input int s0, input int d0, input bit w0,
                         input int s1, input int d1, input bit w1);
        fb_valid = 1'b1; fb_aligned = al;
        fb_unit0 = 2'(u0); fb_src0 = 3'(s0); fb_dst0 = 3'(d0); fb_wr0 = w0;
        fb_unit1 = 2'(u1); fb_src1 = 3'(s1); fb_dst1 = 3'(d1); fb_wr1 = w1;
    endtask

    // Flush, then load a pair on the following edge; returns at the next negedge.
    task automatic fresh_pair(input int u0, input int u1, input bit al,
                              input int s0, input int d0, input bit w0,
                              input int s1, input int d1, input bit w1);
        @(negedge clk); flush = 1'b1; fb_valid = 1'b0; unit_busy = '0;
        @(negedge clk); flush = 1'b0;
        offer(u0, u1, al, s0, d0, w0, s1, d1, w1);
        #1 chk("R6 empty pair requests", int'(fb_advance), 1);
        @(negedge clk); fb_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R10 reset issue0", int'(issue0), 0);
        chk("R10 reset issue1", int'(issue1), 0);
        chk("R10 reset advance", int'(fb_advance), 1);
        @(negedge clk); rst_n = 1'b1;
        #1 chk("R10 empty after reset", int'(fb_advance), 1);

        // Sweep of units, alignment and busy flags (R1 R3 R4 R6 R11).
        for (int u0 = 0; u0 < 3; u0++)
            for (int u1 = 0; u1 < 3; u1++)
                for (int al = 0; al < 2; al++)
                    for (int b = 0; b < 8; b++) begin
                        bit e0, e1;
                        fresh_pair(u0, u1, al[0], 1, 2, 1'b0, 3, 4, 1'b0);
                        unit_busy = 3'(b);
                        e0 = !b[u0];
                        e1 = al[0] && e0 && !b[u1] && (u0 != u1);
                        #1;
                        chk("R1 R3 R4 slot0", int'(issue0), int'(e0));
                        chk("R1 R2 R3 R4 slot1", int'(issue1), int'(e1));
                        chk("R6 advance", int'(fb_advance), int'(e0 && e1));
                        chk("R11 unit0", int'(issue_unit0), u0);
                        chk("R11 unit1", int'(issue_unit1), u1);
                    end

        // R2: slot 0 unit busy, slot 1 free.
        fresh_pair(0, 1, 1'b1, 1, 2, 1'b0, 3, 4, 1'b0);
        unit_busy = 3'b001;
        #1 chk("R2 blocked slot0 issue1", int'(issue1), 0);
        chk("R2 blocked slot0 issue0", int'(issue0), 0);
        @(negedge clk); unit_busy = '0;
        #1 chk("R1 both after release", int'(issue0 && issue1), 1);

        // R4: unaligned pair issues one per cycle.
        fresh_pair(0, 1, 1'b0, 1, 2, 1'b0, 3, 4, 1'b0);
        #1 chk("R4 unaligned first", int'({issue0, issue1}), 2);
        chk("R5 no advance on partial", int'(fb_advance), 0);
        @(negedge clk);
        #1 chk("R4 unaligned second", int'({issue0, issue1}), 1);
        chk("R6 advance on last slot", int'(fb_advance), 1);

        // R8 then R7: slot 1 reads r3 written by slot 0.
        fresh_pair(0, 1, 1'b1, 1, 3, 1'b1, 3, 4, 1'b0);
        #1 chk("R8 raw pair slot0", int'(issue0), 1);
        chk("R8 raw pair slot1", int'(issue1), 0);
        @(negedge clk);
        offer(2, 2, 1'b1, 0, 0, 1'b0, 0, 0, 1'b0);
        #1 chk("R7 pending source stalls", int'(issue1), 0);
        chk("R5 fetch ignored", int'(fb_advance), 0);
        chk("R5 slot1 kept", int'(issue_unit1), 1);
        @(negedge clk); fb_valid = 1'b0; wb_valid = 1'b1; wb_reg = 3'd3;
        #1 chk("R7 clear not yet seen", int'(issue1), 0);
        @(negedge clk); wb_valid = 1'b0;
        #1 chk("R7 lone slot1 issues", int'({issue0, issue1}), 1);
        chk("R6 advance after lone", int'(fb_advance), 1);

        // R8 same-destination pair.
        fresh_pair(0, 2, 1'b1, 1, 7, 1'b1, 2, 7, 1'b1);
        #1 chk("R8 waw pair", int'({issue0, issue1}), 2);

        // R7 pending destination, then R9 flush.
        fresh_pair(0, 1, 1'b1, 0, 5, 1'b1, 1, 6, 1'b1);
        offer(2, 0, 1'b1, 2, 5, 1'b1, 1, 0, 1'b0);
        #1 chk("R1 both issue", int'({issue0, issue1}), 3);
        @(negedge clk); fb_valid = 1'b0;
        #1 chk("R7 pending destination", int'({issue0, issue1}), 0);
        @(negedge clk); flush = 1'b1;
        #1 chk("R9 flush no issue", int'({issue0, issue1}), 0);
        chk("R9 flush no advance", int'(fb_advance), 0);
        @(negedge clk); flush = 1'b0;
        #1 chk("R9 pair emptied", int'(fb_advance), 1);
        chk("R9 nothing issues", int'({issue0, issue1}), 0);
        offer(2, 0, 1'b1, 5, 6, 1'b1, 1, 0, 1'b0);
        @(negedge clk); fb_valid = 1'b0;
        #1 chk("R9 scoreboard cleared", int'({issue0, issue1}), 3);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule